// File: doc/BRIEF.md
# Delta-Rate Sample Address Sequencer

This block walks one streaming sample channel through memory that holds 4-bit codes, two to a byte. Software writes a start unit and a stop unit, each in 256-byte units, a 16-bit rate value, a routing byte and a volume byte. It then sets the start bit. The sequencer produces the byte address to fetch, a read strobe whenever a new byte is needed, and a select that says which half of the byte holds the current code. A decoder further down the chain consumes the code and does the sample decoding.

The playback rate comes from a 16-bit phase accumulator. The accumulator adds the rate value once per sample slot, and the slot length is a fixed number of clocks. Each carry out of the top bit moves one code forward. At the end of the stop unit the sequencer either wraps to the start unit or halts with a one-cycle end strobe, depending on the repeat bit. Routing and volume are only held here and passed on as outputs.

Top module: `sample_addr_seq`

## Requirements
- R1: After reset every register is zero. The bench sees playing, rd_req, end_pulse, out_left, out_right, volume and rd_addr all at 0, with nib_hi at 1.
- R2: A write to the control register at 0x10 takes bit 7 as start and bit 4 as repeat. If bit 0 (reset) is 1, both start and repeat are cleared, whatever bits 7 and 4 hold. The other bits have no effect. Output playing shows the stored start bit.
- R3: A write to 0x11 stores bit 7 as out_left and bit 6 as out_right. A write to 0x1B stores all 8 bits as volume.
- R4: When a control write moves start from 0 to 1, the next cycle shows the following: rd_addr equals the start unit (low byte at 0x12, high byte at 0x13) times 256, nib_hi is 1, rd_req is 1 for that cycle, and the phase accumulator is zero.
- R5: A slot tick comes once every SLOT_DIV clocks, counted from reset. On each tick while playing, the accumulator adds the rate value. The rate value's low byte is at 0x19 and its high byte at 0x1A. Each carry out of bit 15 advances exactly one code. Nothing else advances a code.
- R6: Each byte yields its high nibble first (nib_hi=1), then its low nibble (nib_hi=0). After the low nibble, rd_addr increments by one and nib_hi returns to 1, with a one-cycle rd_req.
- R7: When the code step leaves the low nibble of byte stop*256+255 with repeat set, rd_addr returns to start*256 with nib_hi=1 and rd_req, and playback continues. The stop unit's low byte is at 0x14 and its high byte at 0x15.
- R8: The same step with repeat clear clears start. It raises end_pulse for exactly one cycle and leaves rd_addr and nib_hi unchanged.
- R9: With a rate value of zero, a playing channel never advances.
- R10: A control write with start=1 while start is already 1 does not reload the address or issue rd_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register index |
| wr_data | input | 8 | Register write data |
| rd_addr | output | 24 | Byte address of the current code |
| nib_hi | output | 1 | 1: current code is the high nibble |
| rd_req | output | 1 | One-cycle strobe: fetch byte at rd_addr |
| playing | output | 1 | Stored start bit |
| end_pulse | output | 1 | One-cycle strobe when playback ends without repeat |
| out_left | output | 1 | Left routing enable |
| out_right | output | 1 | Right routing enable |
| volume | output | 8 | Stored volume, 0xFF loudest |

## Verification
A wrong accumulator value cannot be seen directly. It shows up as a code step one or more slots early or late, so the bench compares rd_addr and nib_hi on every cycle against a reference model. A fault then appears within a single slot period. A wrong stop compare or a wrong wrap target shows up as a missing rd_req, or as an address past the stop unit, at the end of the first pass through the sample. A faulty start or repeat bit shows up as a stuck playing output, or as an end_pulse where a wrap was expected.

// File: rtl/sas_pkg.sv
package sas_pkg;
    localparam logic [7:0] REG_CTRL   = 8'h10;
    localparam logic [7:0] REG_ROUTE  = 8'h11;
    localparam logic [7:0] REG_BEG_LO = 8'h12;
    localparam logic [7:0] REG_BEG_HI = 8'h13;
    localparam logic [7:0] REG_FIN_LO = 8'h14;
    localparam logic [7:0] REG_FIN_HI = 8'h15;
    localparam logic [7:0] REG_DN_LO  = 8'h19;
    localparam logic [7:0] REG_DN_HI  = 8'h1A;
    localparam logic [7:0] REG_VOL    = 8'h1B;

    localparam int CTRL_START_BIT = 7;
    localparam int CTRL_RPT_BIT   = 4;
    localparam int CTRL_CLR_BIT   = 0;
endpackage

// File: rtl/sas_slot_div.sv
module sas_slot_div #(
    parameter int DIV = 144
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sas_phase_acc.sv
module sas_phase_acc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         clear,
    input  logic [W-1:0] delta,
    output logic         carry
);
    logic [W-1:0] acc_d, acc_q;
    logic [W:0]   sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, delta};
        carry = tick & run & sum[W];
        if (clear)            acc_d = '0;
        else if (tick && run) acc_d = sum[W-1:0];
        else                  acc_d = acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/sample_addr_seq.sv
module sample_addr_seq #(
    parameter int SLOT_DIV = 144
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic [23:0] rd_addr,
    output logic        nib_hi,
    output logic        rd_req,
    output logic        playing,
    output logic        end_pulse,
    output logic        out_left,
    output logic        out_right,
    output logic [7:0]  volume
);
    import sas_pkg::*;

    localparam int UNIT_W  = 16;
    localparam int OFS_W   = 8;
    localparam int ADDR_W  = UNIT_W + OFS_W;
    localparam int DELTA_W = 16;

    typedef struct packed {
        logic                start;
        logic                rpt;
        logic                left;
        logic                right;
        logic [7:0]          vol;
        logic [UNIT_W-1:0]   beg;
        logic [UNIT_W-1:0]   fin;
        logic [DELTA_W-1:0]  delta;
        logic [ADDR_W-1:0]   addr;
        logic                nib_lo;
        logic                rd;
        logic                fin_p;
    } seq_t;

    seq_t s_d, s_q;
    logic slot_tick;
    logic step;
    logic rise;
    logic last_byte;
    logic ctrl_wr;
    logic n_start, n_rpt;

    sas_slot_div #(.DIV(SLOT_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (slot_tick)
    );

    sas_phase_acc #(.W(DELTA_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (slot_tick),
        .run   (s_q.start),
        .clear (rise),
        .delta (s_q.delta),
        .carry (step)
    );

    always_comb begin
        ctrl_wr   = wr_en && (wr_addr == REG_CTRL);
        n_start   = wr_data[CTRL_START_BIT] & ~wr_data[CTRL_CLR_BIT];
        n_rpt     = wr_data[CTRL_RPT_BIT]   & ~wr_data[CTRL_CLR_BIT];
        rise      = ctrl_wr && n_start && !s_q.start;
        last_byte = (s_q.addr[OFS_W-1:0] == {OFS_W{1'b1}}) &&
                    (s_q.addr[ADDR_W-1:OFS_W] == s_q.fin);

        s_d       = s_q;
        s_d.rd    = 1'b0;
        s_d.fin_p = 1'b0;

        // code stepping from the accumulator carry
        if (step) begin
            if (!s_q.nib_lo) begin
                s_d.nib_lo = 1'b1;
            end else if (last_byte) begin
                if (s_q.rpt) begin
                    s_d.addr   = {s_q.beg, {OFS_W{1'b0}}};
                    s_d.nib_lo = 1'b0;
                    s_d.rd     = 1'b1;
                end else begin
                    s_d.start  = 1'b0;
                    s_d.fin_p  = 1'b1;
                end
            end else begin
                s_d.addr   = s_q.addr + 1'b1;
                s_d.nib_lo = 1'b0;
                s_d.rd     = 1'b1;
            end
        end

        // register writes take priority over stepping
        if (wr_en) begin
            case (wr_addr)
                REG_CTRL: begin
                    s_d.start = n_start;
                    s_d.rpt   = n_rpt;
                    if (rise) begin
                        s_d.addr   = {s_q.beg, {OFS_W{1'b0}}};
                        s_d.nib_lo = 1'b0;
                        s_d.rd     = 1'b1;
                    end
                end
                REG_ROUTE: begin
                    s_d.left  = wr_data[7];
                    s_d.right = wr_data[6];
                end
                REG_BEG_LO: s_d.beg[7:0]    = wr_data;
                REG_BEG_HI: s_d.beg[15:8]   = wr_data;
                REG_FIN_LO: s_d.fin[7:0]    = wr_data;
                REG_FIN_HI: s_d.fin[15:8]   = wr_data;
                REG_DN_LO:  s_d.delta[7:0]  = wr_data;
                REG_DN_HI:  s_d.delta[15:8] = wr_data;
                REG_VOL:    s_d.vol         = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_addr   = s_q.addr;
    assign nib_hi    = ~s_q.nib_lo;
    assign rd_req    = s_q.rd;
    assign playing   = s_q.start;
    assign end_pulse = s_q.fin_p;
    assign out_left  = s_q.left;
    assign out_right = s_q.right;
    assign volume    = s_q.vol;
endmodule

// File: rtl/sas_chk.sv
module sas_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [23:0] rd_addr,
    input logic        nib_hi,
    input logic        rd_req,
    input logic        playing,
    input logic        end_pulse
);
    // R8
    end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |=> !end_pulse);

    // R8
    end_holds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |-> !nib_hi);

    // R6
    fetch_high_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> nib_hi);

    // R4
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(playing) |-> (rd_req && rd_addr[7:0] == 8'h00));

    // R6
    addr_move_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_addr) |-> rd_req);

    // R6
    nib_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(nib_hi) && playing) |-> $stable(rd_addr));
endmodule

bind sample_addr_seq sas_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr   (rd_addr),
    .nib_hi    (nib_hi),
    .rd_req    (rd_req),
    .playing   (playing),
    .end_pulse (end_pulse)
);

// File: tb/sim_sample_addr_seq.sv
`timescale 1ns/1ps
module sim_sample_addr_seq;
    localparam int DIV = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [23:0] rd_addr;
    logic        nib_hi, rd_req, playing, end_pulse, out_left, out_right;
    logic [7:0]  volume;

    int checks = 0;
    int errors = 0;
    int wraps  = 0;
    int ends   = 0;
    int cyc    = 0;
    bit live   = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    sample_addr_seq #(.SLOT_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .nib_hi(nib_hi),
        .rd_req(rd_req), .playing(playing), .end_pulse(end_pulse),
        .out_left(out_left), .out_right(out_right), .volume(volume)
    );

    // reference model state
    int          m_cnt;
    logic [15:0] m_acc, m_delta, m_beg, m_fin;
    logic [23:0] m_addr;
    logic        m_lo, m_start, m_rpt, m_rd, m_end, m_left, m_right;
    logic [7:0]  m_vol;

    task automatic model_reset();
        m_cnt = 0; m_acc = 0; m_delta = 0; m_beg = 0; m_fin = 0;
        m_addr = 0; m_lo = 0; m_start = 0; m_rpt = 0; m_rd = 0; m_end = 0;
        m_left = 0; m_right = 0; m_vol = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            logic tick, step, ns, nr;
            logic [16:0] sum;
            tick  = (m_cnt == DIV - 1);
            m_cnt = tick ? 0 : m_cnt + 1;
            step  = 0;
            m_rd  = 0;
            m_end = 0;
            if (tick && m_start) begin
                sum   = {1'b0, m_acc} + {1'b0, m_delta};
                step  = sum[16];
                m_acc = sum[15:0];
            end
            if (step) begin
                if (!m_lo) m_lo = 1;
                else if (m_addr == {m_fin, 8'hFF}) begin
                    if (m_rpt) begin m_addr = {m_beg, 8'h00}; m_lo = 0; m_rd = 1; end
                    else begin m_start = 0; m_end = 1; end
                end else begin
                    m_addr = m_addr + 1; m_lo = 0; m_rd = 1;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    8'h10: begin
                        ns = wr_data[7] & ~wr_data[0];
                        nr = wr_data[4] & ~wr_data[0];
                        if (ns && !m_start) begin
                            m_addr = {m_beg, 8'h00}; m_lo = 0; m_rd = 1; m_acc = 0;
                        end
                        m_start = ns; m_rpt = nr;
                    end
                    8'h11: begin m_left = wr_data[7]; m_right = wr_data[6]; end
                    8'h12: m_beg[7:0] = wr_data;
                    8'h13: m_beg[15:8] = wr_data;
                    8'h14: m_fin[7:0] = wr_data;
                    8'h15: m_fin[15:8] = wr_data;
                    8'h19: m_delta[7:0] = wr_data;
                    8'h1A: m_delta[15:8] = wr_data;
                    8'h1B: m_vol = wr_data;
                    default: ;
                endcase
            end
        end
    end

    task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // lock-step comparison, away from the active edge
    always @(negedge clk) begin
        if (live && !done) begin
            expect_eq("R6 rd_addr", {8'h0, rd_addr}, {8'h0, m_addr});
            expect_eq("R6 nib_hi", {31'h0, nib_hi}, {31'h0, ~m_lo});
            expect_eq("R4 rd_req", {31'h0, rd_req}, {31'h0, m_rd});
            expect_eq("R2 playing", {31'h0, playing}, {31'h0, m_start});
            expect_eq("R8 end_pulse", {31'h0, end_pulse}, {31'h0, m_end});
            expect_eq("R3 routing", {22'h0, out_left, out_right, volume},
                      {22'h0, m_left, m_right, m_vol});
            if (rd_req && rd_addr == 24'h000500) wraps++;
            if (end_pulse) ends++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd17));
        idle(3);
        // R1 reset state
        expect_eq("R1 rd_addr", {8'h0, rd_addr}, 32'h0);
        expect_eq("R1 flags", {26'h0, playing, rd_req, end_pulse, out_left, out_right, nib_hi},
                  32'h1);
        expect_eq("R1 volume", {24'h0, volume}, 32'h0);
        rst_n = 1;
        live  = 1;

        // R3 routing and volume
        wr(8'h11, 8'hC0);
        wr(8'h1B, 8'hFF);
        expect_eq("R3 left", {31'h0, out_left}, 32'h1);
        expect_eq("R3 vol", {24'h0, volume}, 32'hFF);
        wr(8'h11, 8'h40);
        expect_eq("R3 right only", {30'h0, out_left, out_right}, 32'h1);

        // R7 repeat playback of one unit
        wr(8'h12, 8'h05); wr(8'h13, 8'h00);
        wr(8'h14, 8'h05); wr(8'h15, 8'h00);
        wr(8'h19, 8'hFF); wr(8'h1A, 8'hFF);
        wr(8'h10, 8'h90);
        expect_eq("R4 load addr", {8'h0, rd_addr}, 32'h500);
        expect_eq("R4 rd_req", {31'h0, rd_req}, 32'h1);
        idle(1200);
        // R10 start rewritten while playing
        begin
            logic [23:0] a0;
            a0 = rd_addr;
            wr(8'h10, 8'h90);
            expect_eq("R10 no reload", {31'h0, (rd_addr == 24'h500 && a0 != 24'h500 && rd_req)},
                      32'h0);
        end
        idle(2800);
        expect_eq("R7 wrap count>=2", {31'h0, wraps >= 2}, 32'h1);
        expect_eq("R7 still playing", {31'h0, playing}, 32'h1);

        // R2 reset bit overrides start and repeat
        wr(8'h10, 8'h91);
        expect_eq("R2 clear", {31'h0, playing}, 32'h0);

        // R8 stop without repeat
        wr(8'h12, 8'h07); wr(8'h14, 8'h07);
        ends = 0;
        wr(8'h10, 8'h80);
        idle(2000);
        expect_eq("R8 one end", ends, 32'd1);
        expect_eq("R8 stopped", {31'h0, playing}, 32'h0);
        expect_eq("R8 held addr", {8'h0, rd_addr}, 32'h7FF);

        // R9 zero rate
        wr(8'h19, 8'h00); wr(8'h1A, 8'h00);
        wr(8'h10, 8'h80);
        idle(200);
        expect_eq("R9 no advance", {7'h0, rd_addr, nib_hi}, {7'h0, 24'h700, 1'b1});

        // R5 half rate: a code every two ticks
        wr(8'h10, 8'h01);
        wr(8'h1A, 8'h80);
        wr(8'h10, 8'h90);
        idle(12 * DIV);
        wr(8'h10, 8'h01);

        // random mix, model compared every cycle
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                int k;
                logic [7:0] a, d;
                k = $urandom_range(0, 9);
                d = 8'($urandom);
                case (k)
                    0: begin a = 8'h10; d = (d[1:0] == 0) ? 8'h01 : {d[7], 2'b00, d[4], 3'b000, d[0] & d[5]}; end
                    1: a = 8'h11;
                    2: begin a = 8'h12; d = d & 8'h03; end
                    3: begin a = 8'h13; d = 8'h00; end
                    4: begin a = 8'h14; d = d & 8'h03; end
                    5: begin a = 8'h15; d = 8'h00; end
                    6: a = 8'h19;
                    7: begin a = 8'h1A; d = d | 8'hC0; end
                    8: a = 8'h1B;
                    default: a = 8'($urandom_range(0, 255)) | 8'h20;
                endcase
                wr(a, d);
            end else begin
                idle(1);
            end
        end

        idle(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule